// File: doc/BRIEF.md
# ECG Beat Peak Extractor

This block watches a stream of unsigned ECG samples and, over one heartbeat window, finds the largest positive and the largest negative excursion together with the position of each within the window. The converter that feeds it cannot produce negative codes, so every sample is turned into a signed excursion by subtracting a baseline code supplied alongside it. The baseline is the signal's zero level.

A window opens when the start-of-beat input is raised. It then takes a fixed number of valid samples, 160 by default, numbered from 0. After the last of these it pulses a done strobe for one cycle. At the same time it presents the peak and trough excursions and their indices. Those results stay on the outputs until the next window completes. Downstream logic that labels individual waves or measures intervals reads these results.

Top module: `ecg_peak_scan`

## Requirements
- R1: While reset is asserted and after its release, done_o is 0 and all four result outputs read 0 until the first window completes.
- R2: Each accepted sample is converted to the signed excursion smp_i minus base_i, held in SAMPLE_W+1 bits in two's complement, so the full range from -(2^SAMPLE_W-1) to +(2^SAMPLE_W-1) is represented exactly.
- R3: pk_val_o is the largest excursion in the window, and pk_idx_o is its index, counting accepted samples from 0.
- R4: tr_val_o is the smallest excursion in the window, and tr_idx_o is its index, counting accepted samples from 0.
- R5: When several samples share the extreme excursion, the one with the lowest index is reported.
- R6: A window holds exactly BEAT_LEN accepted samples. done_o is high for exactly one cycle, the cycle after the clock edge that accepts the last sample.
- R7: Between two done pulses, all four result outputs keep their values.
- R8: Raising beat_start_i opens a new window and discards any partial window. A sample that is valid in the same cycle becomes index 0.
- R9: Cycles with smp_valid_i low are ignored. Valid samples that arrive after a window has completed and before the next beat_start_i are also ignored.
- R10: The baseline is taken together with each sample, so base_i may change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_start_i | input | 1 | Opens a new window |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SAMPLE_W | Unsigned sample code |
| base_i | input | SAMPLE_W | Baseline (zero-level) code |
| done_o | output | 1 | One-cycle result strobe |
| pk_val_o | output | SAMPLE_W+1 | Largest signed excursion |
| pk_idx_o | output | clog2(BEAT_LEN) | Index of the largest excursion |
| tr_val_o | output | SAMPLE_W+1 | Smallest signed excursion |
| tr_idx_o | output | clog2(BEAT_LEN) | Index of the smallest excursion |

## Verification
The bench drives several kinds of window, and each targets a specific fault:
- A flat window, where every excursion is zero. A tracker that replaces the stored value on ties reports index 159 instead of 0.
- Repeated extremes at full scale. These expose a subtraction that is one bit too narrow, which wraps the sign, and a tracker that keeps the last tie instead of the first.
- Windows with strobe gaps, extra samples after completion, and a restart in the middle of a window. A design that counts idle cycles, keeps the abandoned partial window, or accepts late samples pulses done at the wrong time or reports foreign peaks.
- A baseline that changes from sample to sample. A design that latches the baseline only once per window gets the wrong excursions.

// File: rtl/ecg_peak_pkg.sv
package ecg_peak_pkg;
   typedef enum logic {PK_HIGH = 1'b0, PK_LOW = 1'b1} pk_pol_e;

   function automatic int idx_bits(input int len);
      return (len < 2) ? 1 : $clog2(len);
   endfunction
endpackage

// File: rtl/ecg_base_diff.sv
module ecg_base_diff #(
   parameter int SAMPLE_W = 12,
   localparam int DIFF_W = SAMPLE_W + 1
) (
   input  logic [SAMPLE_W-1:0]      smp,
   input  logic [SAMPLE_W-1:0]      base,
   output logic signed [DIFF_W-1:0] exc
);
   always_comb exc = $signed({1'b0, smp}) - $signed({1'b0, base});
endmodule

// File: rtl/ecg_beat_counter.sv
module ecg_beat_counter #(
   parameter int BEAT_LEN = 160,
   localparam int IDX_W = ecg_peak_pkg::idx_bits(BEAT_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             valid,
   output logic             take,
   output logic             first,
   output logic             last,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEAT_LEN - 1);

   logic             open_q;
   logic [IDX_W-1:0] cnt_q;

   always_comb begin
      idx   = start ? '0 : cnt_q;
      take  = valid && (start || open_q);
      first = take && (idx == '0);
      last  = take && (idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         open_q <= 1'b1;
         cnt_q  <= valid ? IDX_W'(1) : '0;
      end else if (take) begin
         if (last) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/ecg_extreme_track.sv
module ecg_extreme_track
   import ecg_peak_pkg::*;
#(
   parameter int      VAL_W = 13,
   parameter int      IDX_W = 8,
   parameter pk_pol_e POL   = PK_HIGH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic                    first,
   input  logic signed [VAL_W-1:0] exc,
   input  logic [IDX_W-1:0]        idx,
   output logic signed [VAL_W-1:0] nxt_val,
   output logic [IDX_W-1:0]        nxt_idx
);
   logic signed [VAL_W-1:0] best_q;
   logic [IDX_W-1:0]        best_idx_q;
   logic                    beats;

   generate
      if (POL == PK_HIGH) begin : g_high
         always_comb beats = exc > best_q;
      end else begin : g_low
         always_comb beats = exc < best_q;
      end
   endgenerate

   always_comb begin
      if (take && (first || beats)) begin
         nxt_val = exc;
         nxt_idx = idx;
      end else begin
         nxt_val = best_q;
         nxt_idx = best_idx_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         best_q     <= '0;
         best_idx_q <= '0;
      end else begin
         best_q     <= nxt_val;
         best_idx_q <= nxt_idx;
      end
   end
endmodule

// File: rtl/ecg_peak_scan.sv
module ecg_peak_scan
   import ecg_peak_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int BEAT_LEN = 160,
   localparam int DIFF_W = SAMPLE_W + 1,
   localparam int IDX_W  = idx_bits(BEAT_LEN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     beat_start_i,
   input  logic                     smp_valid_i,
   input  logic [SAMPLE_W-1:0]      smp_i,
   input  logic [SAMPLE_W-1:0]      base_i,
   output logic                     done_o,
   output logic signed [DIFF_W-1:0] pk_val_o,
   output logic [IDX_W-1:0]         pk_idx_o,
   output logic signed [DIFF_W-1:0] tr_val_o,
   output logic [IDX_W-1:0]         tr_idx_o
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("SAMPLE_W must be at least 2");
      end
      if (BEAT_LEN < 2) begin : g_bad_len
         $error("BEAT_LEN must be at least 2");
      end
   endgenerate

   logic                     take, first, last;
   logic [IDX_W-1:0]         idx;
   logic signed [DIFF_W-1:0] exc;
   logic signed [DIFF_W-1:0] hi_val, lo_val;
   logic [IDX_W-1:0]         hi_idx, lo_idx;

   ecg_beat_counter #(.BEAT_LEN(BEAT_LEN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(beat_start_i), .valid(smp_valid_i),
      .take(take), .first(first), .last(last), .idx(idx));

   ecg_base_diff #(.SAMPLE_W(SAMPLE_W)) u_diff (
      .smp(smp_i), .base(base_i), .exc(exc));

   ecg_extreme_track #(.VAL_W(DIFF_W), .IDX_W(IDX_W), .POL(PK_HIGH)) u_hi (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .exc(exc),
      .idx(idx), .nxt_val(hi_val), .nxt_idx(hi_idx));

   ecg_extreme_track #(.VAL_W(DIFF_W), .IDX_W(IDX_W), .POL(PK_LOW)) u_lo (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .exc(exc),
      .idx(idx), .nxt_val(lo_val), .nxt_idx(lo_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         pk_val_o <= '0;
         pk_idx_o <= '0;
         tr_val_o <= '0;
         tr_idx_o <= '0;
      end else begin
         done_o <= last;
         if (last) begin
            pk_val_o <= hi_val;
            pk_idx_o <= hi_idx;
            tr_val_o <= lo_val;
            tr_idx_o <= lo_idx;
         end
      end
   end
endmodule

// File: rtl/ecg_peak_scan_chk.sv
module ecg_peak_scan_chk #(
   parameter int SAMPLE_W = 12,
   parameter int BEAT_LEN = 160,
   localparam int DIFF_W = SAMPLE_W + 1,
   localparam int IDX_W  = ecg_peak_pkg::idx_bits(BEAT_LEN)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     beat_start_i,
   input logic                     smp_valid_i,
   input logic [SAMPLE_W-1:0]      smp_i,
   input logic [SAMPLE_W-1:0]      base_i,
   input logic                     done_o,
   input logic signed [DIFF_W-1:0] pk_val_o,
   input logic [IDX_W-1:0]         pk_idx_o,
   input logic signed [DIFF_W-1:0] tr_val_o,
   input logic [IDX_W-1:0]         tr_idx_o
);
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_start_i |=> !done_o);

   p_results_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(pk_val_o) && $stable(pk_idx_o) &&
                   $stable(tr_val_o) && $stable(tr_idx_o)));

   p_peak_over_trough_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pk_val_o >= tr_val_o));

   p_idx_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((int'(pk_idx_o) < BEAT_LEN) && (int'(tr_idx_o) < BEAT_LEN)));
endmodule

bind ecg_peak_scan ecg_peak_scan_chk #(.SAMPLE_W(SAMPLE_W), .BEAT_LEN(BEAT_LEN)) u_chk (.*);

// File: tb/ecg_peak_scan_test.sv
module ecg_peak_scan_test;
   localparam int SW  = 12;
   localparam int LEN = 160;
   localparam int DW  = SW + 1;
   localparam int IW  = $clog2(LEN);

   typedef struct {
      int    mx; int mxi; int mn; int mni;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic beat_start_i = 1'b0, smp_valid_i = 1'b0;
   logic [SW-1:0] smp_i = '0, base_i = '0;
   logic done_o;
   logic signed [DW-1:0] pk_val_o, tr_val_o;
   logic [IW-1:0] pk_idx_o, tr_idx_o;

   exp_t sb[$];
   int n_chk = 0, n_bad = 0, n_done = 0;
   bit hold_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   ecg_peak_scan #(.SAMPLE_W(SW), .BEAT_LEN(LEN)) uut (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input bit st, input bit v, input int s, input int b);
      beat_start_i = st; smp_valid_i = v;
      smp_i = SW'(s); base_i = SW'(b);
      @(posedge clk); #1;
      beat_start_i = 0; smp_valid_i = 0;
   endtask

   // sample/base pattern per window kind and index
   function automatic void gen(input int kind, input int i, output int s, output int b);
      case (kind)
         0: begin s = i * 20; b = 2048; end
         1: begin s = 1000; b = 1000; end
         2: begin s = (i * 97 + 13) % 4096; b = (i * 31 + 500) % 4096; end
         default: begin
            s = 2000; b = 2000;
            if (i == 10 || i == 90)  begin s = 4095; b = 0; end
            if (i == 40 || i == 150) begin s = 0; b = 4095; end
         end
      endcase
   endfunction

   // Driver: one full window; gaps inserts idle strobes with junk (R9)
   task automatic window(input int kind, input bit gaps, input string tag);
      exp_t e;
      int s, b, d;
      e.tag = tag; e.mx = 0; e.mxi = 0; e.mn = 0; e.mni = 0;
      for (int i = 0; i < LEN; i++) begin
         gen(kind, i, s, b);
         d = s - b;
         if (i == 0 || d > e.mx) begin e.mx = d; e.mxi = i; end
         if (i == 0 || d < e.mn) begin e.mn = d; e.mni = i; end
      end
      sb.push_back(e);
      for (int i = 0; i < LEN; i++) begin
         gen(kind, i, s, b);
         if (gaps && (i % 7 == 3)) begin
            cyc(0, 0, 4095, 0);
            cyc(0, 0, 0, 4095);
         end
         cyc(i == 0, 1, s, b);
      end
   endtask

   // Monitor / scoreboard
   initial begin
      exp_t e;
      int lpv, lpi, ltv, lti;
      lpv = 0; lpi = 0; ltv = 0; lti = 0;
      forever begin
         @(negedge clk);
         if (rst_n && !finished) begin
            if (done_o) begin
               n_done++;
               chk("R7 hold between windows", int'(hold_bad), 0);
               hold_bad = 0;
               if (sb.size() == 0) begin
                  chk("R6/R9 unexpected done", 1, 0);
               end else begin
                  e = sb.pop_front();
                  chk({"R3 peak value ", e.tag}, int'(pk_val_o), e.mx);
                  chk({"R3 peak index ", e.tag}, int'(pk_idx_o), e.mxi);
                  chk({"R4 trough value ", e.tag}, int'(tr_val_o), e.mn);
                  chk({"R4 trough index ", e.tag}, int'(tr_idx_o), e.mni);
               end
               lpv = int'(pk_val_o); lpi = int'(pk_idx_o);
               ltv = int'(tr_val_o); lti = int'(tr_idx_o);
            end else if (int'(pk_val_o) != lpv || int'(pk_idx_o) != lpi ||
                         int'(tr_val_o) != ltv || int'(tr_idx_o) != lti) begin
               hold_bad = 1;
            end
         end
      end
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset done", int'(done_o), 0);
      chk("R1 reset peak", int'(pk_val_o), 0);
      chk("R1 reset trough", int'(tr_val_o), 0);
      rst_n = 1; @(posedge clk); #1;
      chk("R1 after release", int'(done_o) + int'(pk_idx_o) + int'(tr_idx_o), 0);

      window(0, 0, "ramp R2");
      // late samples after completion must be ignored (R9)
      for (int i = 0; i < 5; i++) cyc(0, 1, 4095, 0);
      window(1, 0, "flat ties R5");
      window(2, 1, "gaps varying base R10 R9");
      // partial window then restart (R8)
      for (int i = 0; i < 50; i++) cyc(i == 0, 1, (i == 20) ? 4095 : 0, 2048);
      window(3, 0, "restart full-scale ties R8 R5 R2");
      // start and first sample in separate cycles: start alone, then samples
      cyc(1, 0, 0, 0);
      begin
         exp_t e;
         e.tag = "start without sample R8"; e.mx = 159; e.mxi = 159; e.mn = 0; e.mni = 0;
         sb.push_back(e);
         for (int i = 0; i < LEN; i++) cyc(0, 1, 1000 + i, 1000);
      end
      repeat (4) @(posedge clk);
      #1;
      chk("R6 done count", n_done, 5);
      chk("R6 scoreboard drained", sb.size(), 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule